// File: doc/BRIEF.md
# Pointer-Addressed Transmitter Configuration Register Bank

This block holds the configuration and readback state of a radio transmitter behind a two-wire serial slave. The serial front end is already decoded. It hands the bank a one-cycle start flag that also says whether the transaction is a read or a write, a one-cycle stop flag, the received bytes with a valid strobe, and a one-cycle request for each byte it is about to send back.

In a write transaction the first byte loads an 8-bit register pointer. Each later byte is stored at the pointed address, and the pointer then advances. A read transaction returns the byte at the pointer and advances the pointer after each byte. A host therefore sets the pointer with a short write and then streams reads from that address.

The bank holds five writable command bytes: control, encoder, debug, amplifier level and synthesiser offset. A write-only reset register sits at the next address. The read-only locations are a BCD version byte, two status bytes, and a set of 16-bit telemetry counters. Each counter is read as an upper byte followed by a lower byte, and the two bytes of one read pair always come from one snapshot.

Top module: `txcfg_regbank`

## Requirements
- R1: After reset the five command bytes (addresses 0x00 to 0x04), `amp_enable` and `rd_data` are all 0x00.
- R2: In a write transaction, the first valid byte after the start flag becomes the pointer. The next byte is stored at that address if the address is 0x00 to 0x04, and it appears on the matching configuration output one cycle later.
- R3: Each further byte in the same write transaction is stored at the next address, because the pointer advances by one after every stored byte.
- R4: Each read request returns on `rd_data`, one cycle later, the byte at the pointer, and then advances the pointer by one. The pointer wraps from 0xFF to 0x00.
- R5: The control byte at 0x00 carries the mode in bits 1:0 (00 configuration, 01 sync, 10 data, 11 test) and the amplifier request in bit 7. `amp_enable` is high only when bit 7 is 1 and the mode is not 00.
- R6: A byte written to 0x05 with bit 0 equal to 0 returns every command byte to 0x00 and drops any held snapshot. A byte with bit 0 equal to 1 has no effect. Address 0x05 reads as 0x00.
- R7: Address 0x11 reads the version in BCD, with the major digit in bits 7:4 and the minor digit in bits 3:0. The default is 0x16.
- R8: Address 0x12 returns `status_flags` in bits 1:0, and address 0x13 returns `tx_ready` in bit 0. All other bits of both bytes read 0.
- R9: Telemetry channel k occupies bits 16k+15:16k of `tel_values`. It reads its upper byte at 0x14+2k and its lower byte at 0x15+2k. The channels are underruns (k=0), overruns, buffer fill and RF power.
- R10: Reading an upper byte captures that channel's lower byte. A read of the next address that immediately follows returns the captured byte, even if the input has changed in between. A lower byte read in any other way returns the live value.
- R11: Writes to addresses above 0x05 change no stored byte. Reads of 0x05 and of any address from 0x1C upward return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_start | input | 1 | One-cycle pulse at the start of a transaction |
| xfer_is_read | input | 1 | Qualifies `xfer_start`: 1 read, 0 write |
| xfer_stop | input | 1 | One-cycle pulse at the end of a transaction |
| rx_valid | input | 1 | A received byte is present on `rx_byte` |
| rx_byte | input | 8 | Received byte |
| rd_req | input | 1 | Request for the next read byte |
| status_flags | input | 2 | Status bits shown at 0x12 |
| tx_ready | input | 1 | Buffer-ready flag shown at 0x13 |
| tel_values | input | 64 | Four 16-bit telemetry channels, channel 0 in the low bits |
| rd_data | output | 8 | Byte returned for the last read request |
| ctrl_cfg | output | 8 | Control byte (0x00) |
| enc_cfg | output | 8 | Encoder byte (0x01) |
| dbg_cfg | output | 8 | Debug byte (0x02) |
| pwr_cfg | output | 8 | Amplifier level byte (0x03) |
| synth_cfg | output | 8 | Synthesiser offset byte (0x04) |
| amp_enable | output | 1 | Effective amplifier enable |

## Verification
The assertions check several rules on every cycle:
- reset and soft-reset clearing;
- loading the pointer from the first byte of a write, and the single step it takes on each read;
- that no stored byte changes on writes above 0x05;
- the gating of the amplifier enable by the configuration mode;
- that reads from unmapped addresses return zero;
- that a lower-byte read right after its upper byte returns the captured value.

Only the bench's scenarios can show the rest. These are the multi-byte write streaming, the address map with its version, status and telemetry byte order, pointer wrap at 0xFF, and snapshot coherence when the telemetry input changes between the two byte reads. The bench compares all of these against a behavioural model.

// File: rtl/rb_pkg.sv
// Package: shared address map and transaction states for the register bank.
// Assumes byte-wide registers and an 8-bit pointer.
package rb_pkg;
    localparam int BYTE_W    = 8;
    localparam int NCMD      = 5;
    localparam logic [7:0] ADDR_SRST = 8'h05;
    localparam logic [7:0] ADDR_VER  = 8'h11;
    localparam logic [7:0] ADDR_STAT = 8'h12;
    localparam logic [7:0] ADDR_TXR  = 8'h13;
    localparam logic [7:0] TEL_BASE  = 8'h14;
    localparam logic [1:0] MODE_CFG  = 2'b00;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_PTR  = 2'd1,
        XS_DATA = 2'd2,
        XS_READ = 2'd3
    } xact_state_e;
endpackage

// File: rtl/rb_xact.sv
// Module: transaction sequencer and register pointer.
// Decodes the start, stop and byte strobes into write and read enables.
// The first byte of a write loads the pointer; every stored byte and every read advances it.
// Assumes the front end never asserts start and stop in the same cycle.
module rb_xact
    import rb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xfer_start,
    input  logic       xfer_is_read,
    input  logic       xfer_stop,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       rd_req,
    output logic       wr_en,
    output logic       rd_en,
    output logic [7:0] ptr
);
    xact_state_e state_q;
    logic [7:0]  ptr_q;
    logic        quiet;

    // No start or stop this cycle, so the current phase is live.
    assign quiet = !xfer_start && !xfer_stop;
    assign wr_en = quiet && (state_q == XS_DATA) && rx_valid;
    assign rd_en = quiet && (state_q == XS_READ) && rd_req;
    assign ptr   = ptr_q;

    // Phase tracking and pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
            ptr_q   <= '0;
        end else if (xfer_start) begin
            state_q <= xfer_is_read ? XS_READ : XS_PTR;
        end else if (xfer_stop) begin
            state_q <= XS_IDLE;
        end else begin
            case (state_q)
                XS_PTR: if (rx_valid) begin
                    ptr_q   <= rx_byte;
                    state_q <= XS_DATA;
                end
                XS_DATA: if (rx_valid) ptr_q <= ptr_q + 8'd1;
                XS_READ: if (rd_req) ptr_q <= ptr_q + 8'd1;
                default: ;
            endcase
        end
    end

    assert_ptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && state_q == XS_PTR && rx_valid) |=> (ptr_q == $past(rx_byte)));

    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (ptr_q == 8'($past(ptr_q) + 8'd1)));
endmodule

// File: rtl/rb_cmdregs.sv
// Module: writable command bytes, soft reset and amplifier gating.
// Holds addresses 0..NCMD-1. A write to the reset address with bit 0 clear zeroes them all.
// Assumes wr_addr is only meaningful while wr_en is high.
module rb_cmdregs
    import rb_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [7:0]                   wr_addr,
    input  logic [7:0]                   wr_data,
    output logic [NCMD-1:0][BYTE_W-1:0]  cmd_q,
    output logic                         soft_rst,
    output logic                         amp_enable
);
    assign soft_rst = wr_en && (wr_addr == ADDR_SRST) && !wr_data[0];

    for (genvar g = 0; g < NCMD; g++) begin : g_cmd
        // Storage for one command byte.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst)
                cmd_q[g] <= '0;
            else if (wr_en && wr_addr == 8'(g))
                cmd_q[g] <= wr_data;
        end
    end

    // Amplifier stays off while the mode field selects configuration.
    assign amp_enable = cmd_q[0][7] && (cmd_q[0][1:0] != MODE_CFG);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (cmd_q == '0));

    assert_soft_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_SRST && !wr_data[0]) |=> (cmd_q == '0));

    assert_ro_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > ADDR_SRST) |=> $stable(cmd_q));

    assert_amp_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        amp_enable |-> (cmd_q[0][1:0] != MODE_CFG));
endmodule

// File: rtl/rb_rdpath.sv
// Module: read multiplexer with a lower-byte snapshot for 16-bit counters.
// Reading an upper byte captures that channel's lower byte for an immediately following read.
// Assumes each telemetry channel is two bytes wide.
module rb_rdpath
    import rb_pkg::*;
#(
    parameter int         TEL_CH    = 4,
    parameter logic [3:0] VER_MAJOR = 4'd1,
    parameter logic [3:0] VER_MINOR = 4'd6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en,
    input  logic [7:0]                   rd_addr,
    input  logic                         wr_start,
    input  logic                         soft_rst,
    input  logic [NCMD-1:0][BYTE_W-1:0]  cmd_q,
    input  logic [1:0]                   status_flags,
    input  logic                         tx_ready,
    input  logic [TEL_CH*2*BYTE_W-1:0]   tel_values,
    output logic [7:0]                   rd_data
);
    localparam int TEL_W   = 2 * BYTE_W;
    localparam int TEL_END = int'(TEL_BASE) + 2 * TEL_CH;

    logic [7:0] live;
    logic       up_hit;
    logic [7:0] up_lo;
    logic       snap_v;
    logic [7:0] snap_lo;
    logic [7:0] snap_addr;

    // Live byte for the current pointer, plus upper-byte detection.
    always_comb begin
        live   = '0;
        up_hit = 1'b0;
        up_lo  = '0;
        for (int k = 0; k < NCMD; k++)
            if (rd_addr == 8'(k)) live = cmd_q[k];
        if (rd_addr == ADDR_VER)  live = {VER_MAJOR, VER_MINOR};
        if (rd_addr == ADDR_STAT) live = {6'b0, status_flags};
        if (rd_addr == ADDR_TXR)  live = {7'b0, tx_ready};
        for (int k = 0; k < TEL_CH; k++) begin
            if (rd_addr == 8'(int'(TEL_BASE) + 2 * k)) begin
                live   = tel_values[k*TEL_W+BYTE_W +: BYTE_W];
                up_hit = 1'b1;
                up_lo  = tel_values[k*TEL_W +: BYTE_W];
            end
            if (rd_addr == 8'(int'(TEL_BASE) + 2 * k + 1))
                live = tel_values[k*TEL_W +: BYTE_W];
        end
    end

    // Registered read data and snapshot bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            rd_data   <= '0;
            snap_v    <= 1'b0;
            snap_lo   <= '0;
            snap_addr <= '0;
        end else if (rd_en) begin
            rd_data   <= (snap_v && rd_addr == snap_addr) ? snap_lo : live;
            snap_v    <= up_hit;
            snap_lo   <= up_lo;
            snap_addr <= rd_addr + 8'd1;
        end else if (wr_start) begin
            snap_v <= 1'b0;
        end
    end

    assert_snap_used_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && snap_v && rd_addr == snap_addr && !soft_rst) |=> (rd_data == $past(snap_lo)));

    assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && int'(rd_addr) >= TEL_END && !snap_v) |=> (rd_data == 8'h00));
endmodule

// File: rtl/txcfg_regbank.sv
// Module: top of the pointer-addressed transmitter configuration register bank.
// Wires the transaction sequencer, the command bytes and the read path.
// Assumes a decoded serial front end that delivers one-cycle strobes.
module txcfg_regbank #(
    parameter int         TEL_CH    = 4,
    parameter logic [3:0] VER_MAJOR = 4'd1,
    parameter logic [3:0] VER_MINOR = 4'd6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  xfer_start,
    input  logic                  xfer_is_read,
    input  logic                  xfer_stop,
    input  logic                  rx_valid,
    input  logic [7:0]            rx_byte,
    input  logic                  rd_req,
    input  logic [1:0]            status_flags,
    input  logic                  tx_ready,
    input  logic [TEL_CH*16-1:0]  tel_values,
    output logic [7:0]            rd_data,
    output logic [7:0]            ctrl_cfg,
    output logic [7:0]            enc_cfg,
    output logic [7:0]            dbg_cfg,
    output logic [7:0]            pwr_cfg,
    output logic [7:0]            synth_cfg,
    output logic                  amp_enable
);
    import rb_pkg::*;

    logic                        wr_en;
    logic                        rd_en;
    logic [7:0]                  ptr;
    logic                        soft_rst;
    logic [NCMD-1:0][BYTE_W-1:0] cmd_q;

    rb_xact u_xact (
        .clk          (clk),
        .rst_n        (rst_n),
        .xfer_start   (xfer_start),
        .xfer_is_read (xfer_is_read),
        .xfer_stop    (xfer_stop),
        .rx_valid     (rx_valid),
        .rx_byte      (rx_byte),
        .rd_req       (rd_req),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .ptr          (ptr)
    );

    rb_cmdregs u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (ptr),
        .wr_data    (rx_byte),
        .cmd_q      (cmd_q),
        .soft_rst   (soft_rst),
        .amp_enable (amp_enable)
    );

    rb_rdpath #(
        .TEL_CH    (TEL_CH),
        .VER_MAJOR (VER_MAJOR),
        .VER_MINOR (VER_MINOR)
    ) u_rd (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_en        (rd_en),
        .rd_addr      (ptr),
        .wr_start     (xfer_start && !xfer_is_read),
        .soft_rst     (soft_rst),
        .cmd_q        (cmd_q),
        .status_flags (status_flags),
        .tx_ready     (tx_ready),
        .tel_values   (tel_values),
        .rd_data      (rd_data)
    );

    assign ctrl_cfg  = cmd_q[0];
    assign enc_cfg   = cmd_q[1];
    assign dbg_cfg   = cmd_q[2];
    assign pwr_cfg   = cmd_q[3];
    assign synth_cfg = cmd_q[4];
endmodule

// File: tb/txcfg_regbank_tb.sv
// Bench: behavioural model of the register bank, compared on every clock and after every read.
module txcfg_regbank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start = 1'b0, xfer_is_read = 1'b0, xfer_stop = 1'b0;
    logic        rx_valid = 1'b0, rd_req = 1'b0, tx_ready = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [1:0]  status_flags = '0;
    logic [63:0] tel_values = '0;
    logic [7:0]  rd_data, ctrl_cfg, enc_cfg, dbg_cfg, pwr_cfg, synth_cfg;
    logic        amp_enable;

    int checks = 0, failures = 0;
    bit cmp_on = 0, done = 0;

    // Model state
    logic [7:0] m_reg [5];
    logic [7:0] m_ptr = 0;
    bit         m_snap_v = 0;
    logic [7:0] m_snap_lo, m_snap_addr;

    always #5 clk = ~clk;

    txcfg_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_is_read(xfer_is_read),
        .xfer_stop(xfer_stop), .rx_valid(rx_valid), .rx_byte(rx_byte), .rd_req(rd_req),
        .status_flags(status_flags), .tx_ready(tx_ready), .tel_values(tel_values),
        .rd_data(rd_data), .ctrl_cfg(ctrl_cfg), .enc_cfg(enc_cfg), .dbg_cfg(dbg_cfg),
        .pwr_cfg(pwr_cfg), .synth_cfg(synth_cfg), .amp_enable(amp_enable)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Every-clock comparison of configuration outputs against the model (R2, R3, R5, R6).
    always @(negedge clk) if (cmp_on) begin
        chk("R2 ctrl", ctrl_cfg, m_reg[0]);
        chk("R3 enc", enc_cfg, m_reg[1]);
        chk("R3 dbg", dbg_cfg, m_reg[2]);
        chk("R3 pwr", pwr_cfg, m_reg[3]);
        chk("R3 synth", synth_cfg, m_reg[4]);
        chk("R5 amp_enable", {7'b0, amp_enable},
            {7'b0, (m_reg[0][7] == 1'b1) && (m_reg[0][1:0] != 2'b00)});
    end

    task automatic mdl_write(input logic [7:0] d);
        if (m_ptr < 8'h05) m_reg[m_ptr] = d;
        else if (m_ptr == 8'h05 && d[0] == 1'b0) begin
            foreach (m_reg[i]) m_reg[i] = 8'h00;
            m_snap_v = 0;
        end
        m_ptr = m_ptr + 8'd1;
    endtask

    function automatic logic [7:0] tel_byte(input int ch, input bit hi);
        return hi ? tel_values[ch*16+8 +: 8] : tel_values[ch*16 +: 8];
    endfunction

    task automatic mdl_read(output logic [7:0] e);
        int a = int'(m_ptr);
        if (m_snap_v && m_ptr == m_snap_addr) e = m_snap_lo;
        else if (a < 5) e = m_reg[a];
        else if (a == 8'h11) e = 8'h16;
        else if (a == 8'h12) e = {6'b0, status_flags};
        else if (a == 8'h13) e = {7'b0, tx_ready};
        else if (a >= 8'h14 && a < 8'h1C) e = tel_byte((a - 8'h14) / 2, (a % 2) == 0);
        else e = 8'h00;
        m_snap_v = (a >= 8'h14 && a < 8'h1C && (a % 2) == 0);
        if (m_snap_v) begin
            m_snap_lo = tel_byte((a - 8'h14) / 2, 1'b0);
        end
        m_snap_addr = m_ptr + 8'd1;
        m_ptr = m_ptr + 8'd1;
    endtask

    task automatic wr_txn(input logic [7:0] p, input logic [7:0] d[$]);
        @(negedge clk); xfer_start = 1; xfer_is_read = 0;
        @(posedge clk); #1 m_snap_v = 0;
        @(negedge clk); xfer_start = 0; rx_valid = 1; rx_byte = p;
        @(posedge clk); #1 m_ptr = p;
        foreach (d[i]) begin
            @(negedge clk); rx_byte = d[i];
            @(posedge clk); #1 mdl_write(d[i]);
        end
        @(negedge clk); rx_valid = 0; xfer_stop = 1;
        @(negedge clk); xfer_stop = 0;
    endtask

    task automatic rd_begin();
        @(negedge clk); xfer_start = 1; xfer_is_read = 1;
        @(negedge clk); xfer_start = 0;
    endtask

    task automatic rd_end();
        @(negedge clk); xfer_stop = 1;
        @(negedge clk); xfer_stop = 0;
    endtask

    task automatic rd_one(input string tag);
        logic [7:0] e;
        @(negedge clk); rd_req = 1; mdl_read(e);
        @(negedge clk); rd_req = 0;
        chk(tag, rd_data, e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        foreach (m_reg[i]) m_reg[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        chk("R1 rd_data after reset", rd_data, 8'h00);
        chk("R1 ctrl after reset", ctrl_cfg, 8'h00);
        cmp_on = 1;

        // R5: amplifier request gated by mode
        wr_txn(8'h00, '{8'h81});
        chk("R5 sync+amp", {7'b0, amp_enable}, 8'h01);
        wr_txn(8'h00, '{8'h80});
        chk("R5 config holds amp off", {7'b0, amp_enable}, 8'h00);
        wr_txn(8'h00, '{8'h82});
        wr_txn(8'h00, '{8'h03});

        // R3: streamed write across addresses
        wr_txn(8'h01, '{8'h15, 8'h07, 8'h02, 8'h5A});
        chk("R3 synth streamed", synth_cfg, 8'h5A);

        // R4 / R11: read back 0x00..0x05
        wr_txn(8'h00, '{});
        rd_begin();
        for (int i = 0; i < 6; i++) rd_one("R4 sequential read");
        rd_end();

        // R7 / R8
        status_flags = 2'b10; tx_ready = 1;
        wr_txn(8'h11, '{});
        rd_begin();
        rd_one("R7 version");
        rd_one("R8 status");
        rd_one("R8 tx_ready");
        rd_end();

        // R9: all telemetry bytes
        tel_values = 64'hA1B2_C3D4_E5F6_0718;
        wr_txn(8'h14, '{});
        rd_begin();
        for (int i = 0; i < 8; i++) rd_one("R9 telemetry");
        rd_one("R11 unmapped 0x1C");
        rd_end();

        // R10: snapshot coherence
        wr_txn(8'h16, '{});
        rd_begin();
        rd_one("R10 upper");
        tel_values[23:16] = 8'h99;
        rd_one("R10 lower from snapshot");
        rd_end();
        chk("R10 snapshot byte", rd_data, 8'hF6);
        wr_txn(8'h17, '{});
        rd_begin();
        rd_one("R10 lone lower live");
        rd_end();
        chk("R10 live byte", rd_data, 8'h99);

        // R11: writes to read-only/unmapped ignored
        wr_txn(8'h11, '{8'h55});
        wr_txn(8'h30, '{8'hFF});
        wr_txn(8'h11, '{});
        rd_begin();
        rd_one("R11 version unchanged");
        rd_end();
        wr_txn(8'h40, '{});
        rd_begin();
        rd_one("R11 unmapped read");
        rd_end();

        // R4: wrap
        wr_txn(8'hFF, '{});
        rd_begin();
        rd_one("R4 read 0xFF");
        rd_one("R4 wrap to 0x00");
        rd_end();
        chk("R4 wrap value", rd_data, 8'h03);

        // R6: soft reset
        wr_txn(8'h05, '{8'h01});
        chk("R6 bit0=1 no effect", enc_cfg, 8'h15);
        wr_txn(8'h05, '{8'hFE});
        chk("R6 soft reset ctrl", ctrl_cfg, 8'h00);
        chk("R6 soft reset synth", synth_cfg, 8'h00);
        wr_txn(8'h05, '{});
        rd_begin();
        rd_one("R6 reset reg reads zero");
        rd_end();

        cmp_on = 0;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule